// File: doc/BRIEF.md
# Leveled Interrupt Priority Controller

This block picks which of 24 interrupt request lines, if any, the CPU should service next. Each line has a 2-bit priority level. Level 0 is the most urgent and level 3 the least. The levels sit in six 8-bit level registers, four fields per register. A request is eligible only when three things hold: the line is asserted, the CPU's interrupt enable flag is set, and the request's level is numerically below the CPU's current level. Among the eligible requests, the lowest level wins. A tie goes to the lowest request number.

The winner is presented on registered outputs, one clock after the inputs that produced it. These outputs are a take strobe, the request number, and the address of the upper byte of its vector. The lower byte of the vector lives at that address plus one. When the CPU acknowledges a presented request, the block hands back that request's level, which the CPU loads as its new current level. Requests are level-sensitive and are never latched, so a source keeps its line high until software clears it. Three request numbers are not connected and can never win.

Top module: `irq_level_ctrl`

## Requirements
- R1: After reset every level field holds 3. No request is taken then, whatever the CPU level or enable state.
- R2: A write with `cfg_sel` = k (0..5) loads `cfg_wdata` into level register k. Bits [2j+1:2j] of that register become the level of request 4k+j, for j = 0..3. The new levels govern arbitration from the next clock edge on.
- R3: A request is taken only if its level is numerically lower than `cpu_lvl`. An equal or higher level is never taken, and a `cpu_lvl` of 0 blocks everything.
- R4: While `cpu_ie` is 0, `take` stays 0.
- R5: Among eligible requests the lowest level wins. Among equal levels the lowest request number wins.
- R6: `win_vec` equals 0xFFFA minus twice `win_id`, giving 0xFFFA for request 0 and 0xFFCC for request 23.
- R7: Requests 11, 17 and 21 are ignored whatever their line state or level field.
- R8: `take`, `win_id` and `win_vec` are registered, reflecting the inputs at the previous clock edge. `take` falls one cycle after the last eligible request is removed.
- R9: An `ack` sampled while `take` is 1 gives `lvl_load` = 1 on the next cycle, with `new_lvl` equal to the winner's level. An `ack` while `take` is 0 gives no `lvl_load`.
- R10: A write with `cfg_sel` of 6 or 7 changes no level field.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req | input | 24 | Level-sensitive request lines, bit n is request n |
| cfg_we | input | 1 | Level register write strobe |
| cfg_sel | input | 3 | Level register index |
| cfg_wdata | input | 8 | Level register write data |
| cpu_ie | input | 1 | CPU interrupt enable flag |
| cpu_lvl | input | 2 | CPU current interrupt level |
| ack | input | 1 | CPU accepts the presented request |
| take | output | 1 | A request is presented to the CPU |
| win_id | output | 5 | Number of the presented request |
| win_vec | output | 16 | Upper-byte vector address of the presented request |
| lvl_load | output | 1 | One-cycle strobe: load `new_lvl` into the CPU |
| new_lvl | output | 2 | Level for the CPU to adopt after an acknowledge |

## Verification
The levels are programmed to a mixed pattern, and the table then drives request sets that separate the ordering rules. In one set, a low-numbered request at a worse level competes with a higher-numbered request at a better level, which shows that level beats index. Other sets place equal levels side by side, which exposes the tie rule. Requests at exactly the CPU level show whether the comparison is strict. Unused lines are programmed to the most urgent level and paired with live lines, so any leak of an unused line would change the winner. Writes to the two out-of-range indices are chosen so that a decoder which wraps the index would visibly raise a blocked request.

// File: rtl/irq_level_pkg.sv
package irq_level_pkg;

  localparam int unsigned DEF_NUM_REQ = 24;
  localparam int unsigned DEF_LVL_W   = 2;
  localparam int unsigned DEF_FIELDS  = 4;
  localparam int unsigned DEF_ADDR_W  = 16;
  localparam logic [31:0] DEF_VEC_TOP = 32'h0000_FFFA;
  localparam int unsigned DEF_VEC_STEP = 2;

  // Vector address of request id: descends from the top entry by a fixed step
  function automatic logic [31:0] vec_of(input logic [31:0] top,
                                         input int unsigned id,
                                         input int unsigned step);
    return top - 32'(id * step);
  endfunction

  // A request level passes the CPU mask only if it is strictly more urgent
  function automatic logic lvl_beats(input int unsigned req_lvl,
                                     input int unsigned cur_lvl);
    return req_lvl < cur_lvl;
  endfunction

endpackage

// File: rtl/ilc_level_regs.sv
module ilc_level_regs #(
  parameter int unsigned NUM_REGS = 6,
  parameter int unsigned REG_W    = 8,
  parameter int unsigned SEL_W    = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cfg_we,
  input  logic [SEL_W-1:0]          cfg_sel,
  input  logic [REG_W-1:0]          cfg_wdata,
  output logic [NUM_REGS*REG_W-1:0] lvl_flat
);

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    logic [REG_W-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  q <= '1;
      else if (cfg_we && (cfg_sel == SEL_W'(r)))   q <= cfg_wdata;
    end
    assign lvl_flat[r*REG_W +: REG_W] = q;
  end

  // R10
  bad_sel_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && (32'(cfg_sel) >= NUM_REGS)) |=> $stable(lvl_flat));

endmodule

// File: rtl/ilc_arbiter.sv
module ilc_arbiter
  import irq_level_pkg::*;
#(
  parameter int unsigned       NUM_REQ     = 24,
  parameter int unsigned       LVL_W       = 2,
  parameter int unsigned       ID_W        = 5,
  parameter logic [NUM_REQ-1:0] UNUSED_MASK = '0
) (
  input  logic [NUM_REQ-1:0]       irq_req,
  input  logic [NUM_REQ*LVL_W-1:0] lvl_flat,
  input  logic                     cpu_ie,
  input  logic [LVL_W-1:0]         cpu_lvl,
  output logic                     any,
  output logic [ID_W-1:0]          best_id,
  output logic [LVL_W-1:0]         best_lvl
);

  logic [NUM_REQ-1:0] elig;

  for (genvar g = 0; g < NUM_REQ; g++) begin : g_elig
    logic [LVL_W-1:0] my_lvl;
    assign my_lvl  = lvl_flat[g*LVL_W +: LVL_W];
    assign elig[g] = irq_req[g] && !UNUSED_MASK[g] && cpu_ie &&
                     lvl_beats(int'(my_lvl), int'(cpu_lvl));
  end

  // Ascending scan: a later request replaces the holder only on a strictly
  // better level, so equal levels keep the lowest number.
  always_comb begin
    any      = 1'b0;
    best_id  = '0;
    best_lvl = '1;
    for (int i = 0; i < NUM_REQ; i++) begin
      if (elig[i] && (!any || (lvl_flat[i*LVL_W +: LVL_W] < best_lvl))) begin
        any      = 1'b1;
        best_id  = ID_W'(i);
        best_lvl = lvl_flat[i*LVL_W +: LVL_W];
      end
    end
  end

endmodule

// File: rtl/ilc_vec_gen.sv
module ilc_vec_gen
  import irq_level_pkg::*;
#(
  parameter int unsigned ID_W     = 5,
  parameter int unsigned ADDR_W   = 16,
  parameter logic [31:0] VEC_TOP  = 32'h0000_FFFA,
  parameter int unsigned VEC_STEP = 2
) (
  input  logic [ID_W-1:0]   id,
  output logic [ADDR_W-1:0] vec
);

  logic [31:0] full;
  assign full = vec_of(VEC_TOP, int'(id), VEC_STEP);
  assign vec  = full[ADDR_W-1:0];

endmodule

// File: rtl/irq_level_ctrl.sv
module irq_level_ctrl
  import irq_level_pkg::*;
#(
  parameter int unsigned        NUM_REQ     = DEF_NUM_REQ,
  parameter int unsigned        LVL_W       = DEF_LVL_W,
  parameter int unsigned        FIELDS      = DEF_FIELDS,
  parameter int unsigned        ADDR_W      = DEF_ADDR_W,
  parameter logic [31:0]        VEC_TOP     = DEF_VEC_TOP,
  parameter int unsigned        VEC_STEP    = DEF_VEC_STEP,
  parameter logic [NUM_REQ-1:0] UNUSED_MASK = 24'h22_0800,
  localparam int unsigned REG_W    = FIELDS * LVL_W,
  localparam int unsigned NUM_REGS = NUM_REQ / FIELDS,
  localparam int unsigned SEL_W    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
  localparam int unsigned ID_W     = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_REQ-1:0]  irq_req,
  input  logic                cfg_we,
  input  logic [SEL_W-1:0]    cfg_sel,
  input  logic [REG_W-1:0]    cfg_wdata,
  input  logic                cpu_ie,
  input  logic [LVL_W-1:0]    cpu_lvl,
  input  logic                ack,
  output logic                take,
  output logic [ID_W-1:0]     win_id,
  output logic [ADDR_W-1:0]   win_vec,
  output logic                lvl_load,
  output logic [LVL_W-1:0]    new_lvl
);

  logic [NUM_REQ*LVL_W-1:0] lvl_flat;
  logic                     arb_any;
  logic [ID_W-1:0]          arb_id;
  logic [LVL_W-1:0]         arb_lvl;
  logic [ADDR_W-1:0]        arb_vec;
  logic [LVL_W-1:0]         win_lvl_q;
  logic                     ack_hit;

  ilc_level_regs #(
    .NUM_REGS (NUM_REGS),
    .REG_W    (REG_W),
    .SEL_W    (SEL_W)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_sel   (cfg_sel),
    .cfg_wdata (cfg_wdata),
    .lvl_flat  (lvl_flat)
  );

  ilc_arbiter #(
    .NUM_REQ     (NUM_REQ),
    .LVL_W       (LVL_W),
    .ID_W        (ID_W),
    .UNUSED_MASK (UNUSED_MASK)
  ) u_arb (
    .irq_req  (irq_req),
    .lvl_flat (lvl_flat),
    .cpu_ie   (cpu_ie),
    .cpu_lvl  (cpu_lvl),
    .any      (arb_any),
    .best_id  (arb_id),
    .best_lvl (arb_lvl)
  );

  ilc_vec_gen #(
    .ID_W     (ID_W),
    .ADDR_W   (ADDR_W),
    .VEC_TOP  (VEC_TOP),
    .VEC_STEP (VEC_STEP)
  ) u_vec (
    .id  (arb_id),
    .vec (arb_vec)
  );

  // Presentation stage
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      take      <= 1'b0;
      win_id    <= '0;
      win_vec   <= '0;
      win_lvl_q <= '1;
    end else begin
      take      <= arb_any;
      win_id    <= arb_id;
      win_vec   <= arb_vec;
      win_lvl_q <= arb_lvl;
    end
  end

  // Acknowledge: hand the presented level back to the CPU
  assign ack_hit = ack && take;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_load <= 1'b0;
      new_lvl  <= '1;
    end else begin
      lvl_load <= ack_hit;
      if (ack_hit) new_lvl <= win_lvl_q;
    end
  end

  // Checker state: request lines as seen at the previous edge
  logic [NUM_REQ-1:0] req_prev;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_prev <= '0;
    else        req_prev <= irq_req;
  end

  // R4
  take_needs_ie_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> $past(cpu_ie));

  // R3
  take_below_cur_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> (win_lvl_q < $past(cpu_lvl)));

  // R7
  unused_never_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> !UNUSED_MASK[win_id]);

  // R8
  winner_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> req_prev[win_id]);

  // R9
  load_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_load |-> ($past(ack) && $past(take)));

  // R9
  load_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_load |-> (new_lvl == $past(win_lvl_q)));

  // R6
  vec_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> (win_vec[0] == 1'b0));

endmodule

// File: tb/irq_level_ctrl_bench.sv
module irq_level_ctrl_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] irq_req = '0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_sel = '0;
  logic [7:0]  cfg_wdata = '0;
  logic        cpu_ie = 1'b0;
  logic [1:0]  cpu_lvl = 2'd3;
  logic        ack = 1'b0;
  logic        take;
  logic [4:0]  win_id;
  logic [15:0] win_vec;
  logic        lvl_load;
  logic [1:0]  new_lvl;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  irq_level_ctrl u_irq_level_ctrl (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .cfg_we(cfg_we),
    .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .cpu_ie(cpu_ie),
    .cpu_lvl(cpu_lvl), .ack(ack), .take(take), .win_id(win_id),
    .win_vec(win_vec), .lvl_load(lvl_load), .new_lvl(new_lvl)
  );

  // {req[23:0], ie, cpu_lvl[1:0], exp_take, exp_id[4:0]}
  localparam int NV = 19;
  localparam logic [32:0] TBL [NV] = '{
    {24'h000000, 1'b1, 2'd3, 1'b0, 5'd0 },  // R3 nothing pending
    {24'h000001, 1'b1, 2'd3, 1'b1, 5'd0 },  // R3 lvl2 under 3
    {24'h000001, 1'b1, 2'd2, 1'b0, 5'd0 },  // R3 equal level blocked
    {24'h000003, 1'b1, 2'd3, 1'b1, 5'd1 },  // R5 level beats index
    {24'h00000A, 1'b1, 2'd2, 1'b1, 5'd1 },  // R5 tie to lower number
    {24'h000028, 1'b1, 2'd3, 1'b1, 5'd3 },  // R5 tie across registers
    {24'h000004, 1'b0, 2'd3, 1'b0, 5'd0 },  // R4 enable off
    {24'h000104, 1'b1, 2'd1, 1'b1, 5'd2 },  // R5 level 0 tie
    {24'h000800, 1'b1, 2'd3, 1'b0, 5'd0 },  // R7 irq11 alone
    {24'h100800, 1'b1, 2'd1, 1'b1, 5'd20},  // R7 irq11 vs irq20
    {24'hA00000, 1'b1, 2'd3, 1'b1, 5'd23},  // R7 irq21 vs irq23
    {24'h060000, 1'b1, 2'd2, 1'b1, 5'd18},  // R7 irq17 vs irq18
    {24'h000200, 1'b1, 2'd3, 1'b0, 5'd0 },  // R3 level 3 never taken
    {24'h003000, 1'b1, 2'd3, 1'b1, 5'd12},  // R5 tie at level 2
    {24'h410000, 1'b1, 2'd3, 1'b0, 5'd0 },  // R3 two level-3 requests
    {24'hFFFFFF, 1'b1, 2'd1, 1'b1, 5'd2 },  // R5 all pending
    {24'hFFFFFF, 1'b1, 2'd0, 1'b0, 5'd0 },  // R3 level 0 blocks all
    {24'hFFFFFF, 1'b0, 2'd3, 1'b0, 5'd0 },  // R4 all pending, enable off
    {24'h800000, 1'b1, 2'd2, 1'b1, 5'd23}   // R6 last vector
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_win(input string tag, input logic [4:0] id);
    logic [15:0] ev;
    ev = 16'd65530 - 16'(id) - 16'(id);
    chk({tag, " take"}, 32'(take), 32'd1);
    chk({tag, " id"}, 32'(win_id), 32'(id));
    chk({tag, " vec"}, 32'(win_vec), 32'(ev));
  endtask

  task automatic wr(input logic [2:0] sel, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic apply(input logic [23:0] r, input logic ie, input logic [1:0] cl);
    @(negedge clk);
    irq_req = r; cpu_ie = ie; cpu_lvl = cl;
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 take in reset", 32'(take), 32'd0);
    rst_n = 1'b1;

    // R1: every field at 3 after reset, nothing passes even at cpu level 3
    apply(24'hFFFFFF, 1'b1, 2'd3);
    chk("R1 reset levels", 32'(take), 32'd0);
    apply(24'h000000, 1'b1, 2'd3);

    // R2: field j of register k is request 4k+j
    wr(3'd0, 8'h46);
    wr(3'd1, 8'h55);
    wr(3'd2, 8'h2C);
    wr(3'd3, 8'hAA);
    wr(3'd4, 8'h93);
    wr(3'd5, 8'h70);

    for (int i = 0; i < NV; i++) begin
      logic [32:0] e;
      e = TBL[i];
      apply(e[32:9], e[8], e[7:6]);
      if (e[5]) chk_win($sformatf("R5 vec%0d", i), e[4:0]);
      else      chk($sformatf("R3 vec%0d take", i), 32'(take), 32'd0);
    end

    // R8: take drops one cycle after removal
    apply(24'h000002, 1'b1, 2'd3);
    chk_win("R8 present", 5'd1);
    apply(24'h000000, 1'b1, 2'd3);
    chk("R8 removed", 32'(take), 32'd0);

    // R9: acknowledge returns the winner level (irq1 at level 1)
    apply(24'h000002, 1'b1, 2'd3);
    @(negedge clk);
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
    chk("R9 load strobe", 32'(lvl_load), 32'd1);
    chk("R9 new level", 32'(new_lvl), 32'd1);
    @(negedge clk);
    chk("R9 strobe single", 32'(lvl_load), 32'd0);
    apply(24'h000000, 1'b1, 2'd3);
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
    chk("R9 ack without take", 32'(lvl_load), 32'd0);

    // R10: out-of-range writes; a wrapped index would make irq9/irq12 level 0
    wr(3'd6, 8'h00);
    wr(3'd7, 8'h00);
    apply(24'h001200, 1'b1, 2'd1);
    chk("R10 ignored writes", 32'(take), 32'd0);

    // R2: rewrite register 0, irq0 to level 0 ties with irq2
    wr(3'd0, 8'h44);
    apply(24'h000005, 1'b1, 2'd3);
    chk_win("R2 rewrite", 5'd0);

    // R6: first vector address
    apply(24'h000001, 1'b1, 2'd1);
    chk_win("R6 first vector", 5'd0);

    apply(24'h000000, 1'b0, 2'd3);
    finish_run();
  end

endmodule